// File: doc/BRIEF.md
# Bus Idle Timer

This block decides when a single-wire control bus shared by consumer devices has been quiet long enough for a new frame to begin. It counts half-bit-period ticks while the line rests at its idle (high) level. When the count reaches the required idle length, it raises a grant. The grant stays high until the transmitter reports that it has started its frame.

The required idle length comes from a 3-bit code. A nonzero code `n` asks for `n - 0.5` nominal bit periods. Code zero falls back to a default length chosen by a 2-bit class input, which states the situation: a retry after a failed attempt, a new initiator taking the bus, or the same initiator sending its next frame.

A mode bit selects what starts the count:
- the software transmit-start request, or
- the end of any message, whether sent or received.

If the line is pulled low during the count, the count starts again from zero and a one-cycle error pulse is raised.

Top module: `sft_timer`

## Requirements
- R1: After reset (synchronous, active high) `bus_free` and `line_err` are low and the half-period count is zero. A reset in the middle of a count abandons it, so a following tick grants nothing.
- R2: With a nonzero `free_code` n, `bus_free` rises in the cycle after the (2n-1)-th qualifying tick following the start event, and not earlier. A qualifying tick is a cycle with `half_tick` high and `line_hi` high.
- R3: With `free_code` 0 the limit follows `idle_class`. Encoding 0 (retry) needs 6 ticks (3 periods). Encoding 1 (new initiator) needs 10 ticks (5 periods). Encodings 2 (next frame) and 3 (reserved, treated as 2) need 14 ticks (7 periods).
- R4: With `auto_start` 0 a `tx_req` pulse starts the count. `tx_eom` and `rx_eom` are ignored.
- R5: With `auto_start` 1 either `tx_eom` or `rx_eom` starts the count. `tx_req` is ignored.
- R6: A low `line_hi` while counting clears the count. `line_err` is high for exactly the following cycle. Counting resumes from zero on the later qualifying ticks.
- R7: Once high, `bus_free` stays high until `frame_ack` is sampled high. It then drops in the next cycle and the count returns to zero. While granted, start events and a low line are ignored.
- R8: A start event while already counting restarts the count from zero.
- R9: Ticks outside a count have no effect. `line_err` is raised only for a low line seen while counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-cycle pulse every half nominal bit period |
| line_hi | input | 1 | Bus line level, 1 = idle/high |
| free_code | input | 3 | Idle length code, 0 = default rule |
| auto_start | input | 1 | 0: count starts on `tx_req`; 1: count starts at end of message |
| tx_req | input | 1 | Software transmit-start request pulse |
| tx_eom | input | 1 | End of transmitted message pulse |
| rx_eom | input | 1 | End of received message pulse |
| idle_class | input | 2 | Default idle class used when `free_code` is 0 |
| frame_ack | input | 1 | Transmitter has started its frame; releases the grant |
| bus_free | output | 1 | Bus idle long enough, transmission may start |
| line_err | output | 1 | One-cycle pulse: line went low during the count |

## Verification
The assertions check, on every cycle, the following behaviours:
- the grant holds until it is acknowledged and is then released;
- a low line during a count always clears it and pulses the error;
- the error only follows a counting cycle;
- the grant only rises right after a qualifying tick.

The actual idle lengths per code and per default class depend on the programmed limit. The same holds for the choice between the two start modes and for restart-on-restart. Only the bench's tick-by-tick scenarios show these.

// File: rtl/sft_pkg.sv
package sft_pkg;

    // Controller state of the idle timer.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_GRANT = 2'd2
    } sft_state_e;

    // Default idle classes used when the free-time code is zero.
    typedef enum logic [1:0] {
        CLS_RETRY   = 2'd0,
        CLS_NEWINIT = 2'd1,
        CLS_NEXT    = 2'd2,
        CLS_RSVD    = 2'd3
    } sft_class_e;

    // Required idle time in half-period ticks.
    // Nonzero code n -> (n - 0.5) periods -> 2n-1 half ticks.
    function automatic int half_limit(input int code, input int cls,
                                      input int retry_bp, input int new_bp,
                                      input int next_bp);
        if (code != 0) return 2 * code - 1;
        case (cls)
            0:       return 2 * retry_bp;
            1:       return 2 * new_bp;
            default: return 2 * next_bp;
        endcase
    endfunction

    // Largest limit any code or class can ask for.
    function automatic int max_half(input int code_w, input int retry_bp,
                                    input int new_bp, input int next_bp);
        int m;
        m = 2 * ((1 << code_w) - 1) - 1;
        if (2 * retry_bp > m) m = 2 * retry_bp;
        if (2 * new_bp > m)   m = 2 * new_bp;
        if (2 * next_bp > m)  m = 2 * next_bp;
        return m;
    endfunction

endpackage

// File: rtl/sft_start_sel.sv
// Picks the start event according to the start mode.
module sft_start_sel (
    input  logic auto_start,
    input  logic tx_req,
    input  logic tx_eom,
    input  logic rx_eom,
    output logic arm
);
    always_comb begin
        if (auto_start) arm = tx_eom | rx_eom;
        else            arm = tx_req;
    end
endmodule

// File: rtl/sft_limit.sv
// Turns the free-time code and default class into a half-tick limit.
module sft_limit
    import sft_pkg::*;
#(
    parameter int CODE_W   = 3,
    parameter int W        = 4,
    parameter int RETRY_BP = 3,
    parameter int NEW_BP   = 5,
    parameter int NEXT_BP  = 7
) (
    input  logic [CODE_W-1:0] code,
    input  logic [1:0]        cls,
    output logic [W-1:0]      limit
);
    always_comb begin
        limit = W'(half_limit(int'(code), int'(cls), RETRY_BP, NEW_BP, NEXT_BP));
    end
endmodule

// File: rtl/sft_halfcnt.sv
// Half-period counter with clear priority over increment.
module sft_halfcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (en)    cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/sft_timer.sv
module sft_timer
    import sft_pkg::*;
#(
    parameter int CODE_W   = 3,
    parameter int RETRY_BP = 3,
    parameter int NEW_BP   = 5,
    parameter int NEXT_BP  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_tick,
    input  logic              line_hi,
    input  logic [CODE_W-1:0] free_code,
    input  logic              auto_start,
    input  logic              tx_req,
    input  logic              tx_eom,
    input  logic              rx_eom,
    input  logic [1:0]        idle_class,
    input  logic              frame_ack,
    output logic              bus_free,
    output logic              line_err
);
    localparam int MAXH  = max_half(CODE_W, RETRY_BP, NEW_BP, NEXT_BP);
    localparam int CNT_W = $clog2(MAXH + 1);

    sft_state_e       st, st_nx;
    logic             arm, arm_ok, counting, granted;
    logic             cnt_clr, cnt_en, reach;
    logic [CNT_W-1:0] cnt, limit;
    logic [CNT_W:0]   cnt_nx;

    sft_start_sel i_sel (
        .auto_start (auto_start),
        .tx_req     (tx_req),
        .tx_eom     (tx_eom),
        .rx_eom     (rx_eom),
        .arm        (arm)
    );

    sft_limit #(
        .CODE_W   (CODE_W),
        .W        (CNT_W),
        .RETRY_BP (RETRY_BP),
        .NEW_BP   (NEW_BP),
        .NEXT_BP  (NEXT_BP)
    ) i_lim (
        .code  (free_code),
        .cls   (idle_class),
        .limit (limit)
    );

    assign counting = (st == ST_COUNT);
    assign granted  = (st == ST_GRANT);
    assign arm_ok   = arm && !granted;
    assign cnt_en   = counting && line_hi && half_tick;
    assign cnt_clr  = arm_ok || (counting && !line_hi) || (granted && frame_ack);
    assign cnt_nx   = {1'b0, cnt} + (CNT_W + 1)'(1);
    assign reach    = cnt_nx >= {1'b0, limit};

    sft_halfcnt #(.W(CNT_W)) i_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .en  (cnt_en),
        .cnt (cnt)
    );

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:  if (arm) st_nx = ST_COUNT;
            ST_COUNT: if (!arm && cnt_en && reach) st_nx = ST_GRANT;
            ST_GRANT: if (frame_ack) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            line_err <= 1'b0;
        end else begin
            st       <= st_nx;
            line_err <= counting && !line_hi;
        end
    end

    assign bus_free = granted;

endmodule

// File: rtl/sft_timer_chk.sv
module sft_timer_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         half_tick,
    input logic         line_hi,
    input logic         frame_ack,
    input logic         bus_free,
    input logic         line_err,
    input logic         counting,
    input logic [W-1:0] cnt
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!bus_free && !line_err && cnt == '0));

    p_grant_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_free && !frame_ack) |=> bus_free);

    p_ack_release_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_free && frame_ack) |=> (!bus_free && cnt == '0));

    p_low_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (counting && !line_hi) |=> (line_err && cnt == '0));

    p_err_only_counting_r9: assert property (@(posedge clk) disable iff (rst)
        line_err |-> $past(counting));

    p_grant_after_tick_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_free) |-> $past(half_tick && line_hi && counting));
endmodule

bind sft_timer sft_timer_chk #(.W(CNT_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .half_tick (half_tick),
    .line_hi   (line_hi),
    .frame_ack (frame_ack),
    .bus_free  (bus_free),
    .line_err  (line_err),
    .counting  (counting),
    .cnt       (cnt)
);

// File: tb/test_sft_timer.sv
module test_sft_timer;
    localparam int CLK_P = 10;
    localparam int WDOG  = 20000;
    localparam int NVEC  = 9;

    // {code[11:9], class[8:7], mode[6], src[5] (0 tx_eom, 1 rx_eom), ticks[4:0]}
    localparam logic [11:0] VEC [NVEC] = '{
        {3'd1, 2'd0, 1'b0, 1'b0, 5'd1},   // R2 code 1 -> 1
        {3'd2, 2'd0, 1'b0, 1'b0, 5'd3},   // R2 code 2 -> 3
        {3'd4, 2'd0, 1'b1, 1'b0, 5'd7},   // R2 R5 code 4 -> 7
        {3'd7, 2'd0, 1'b0, 1'b0, 5'd13},  // R2 code 7 -> 13
        {3'd0, 2'd0, 1'b0, 1'b0, 5'd6},   // R3 retry
        {3'd0, 2'd1, 1'b1, 1'b1, 5'd10},  // R3 R5 new initiator
        {3'd0, 2'd2, 1'b0, 1'b0, 5'd14},  // R3 next frame
        {3'd0, 2'd3, 1'b1, 1'b0, 5'd14},  // R3 reserved class
        {3'd3, 2'd2, 1'b1, 1'b1, 5'd5}    // R2 class ignored for nonzero code
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       half_tick = 1'b0, line_hi = 1'b1;
    logic [2:0] free_code = 3'd0;
    logic       auto_start = 1'b0, tx_req = 1'b0, tx_eom = 1'b0, rx_eom = 1'b0;
    logic [1:0] idle_class = 2'd0;
    logic       frame_ack = 1'b0;
    logic       bus_free, line_err;
    int         nchk = 0, nfail = 0;

    always #(CLK_P / 2) clk = ~clk;

    sft_timer i_sft_timer (
        .clk        (clk),
        .rst        (rst),
        .half_tick  (half_tick),
        .line_hi    (line_hi),
        .free_code  (free_code),
        .auto_start (auto_start),
        .tx_req     (tx_req),
        .tx_eom     (tx_eom),
        .rx_eom     (rx_eom),
        .idle_class (idle_class),
        .frame_ack  (frame_ack),
        .bus_free   (bus_free),
        .line_err   (line_err)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // All drive tasks start and end at a falling edge.
    task automatic tick();
        half_tick = 1'b1;
        @(negedge clk);
        half_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic start_evt(input logic mode, input logic src);
        if (!mode)     tx_req = 1'b1;
        else if (!src) tx_eom = 1'b1;
        else           rx_eom = 1'b1;
        @(negedge clk);
        tx_req = 1'b0; tx_eom = 1'b0; rx_eom = 1'b0;
    endtask

    task automatic ack();
        frame_ack = 1'b1;
        @(negedge clk);
        frame_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(bus_free, 1'b0, "R1 reset bus_free");
        chk(line_err, 1'b0, "R1 reset line_err");

        // R9: ticks without a start event do nothing
        free_code = 3'd1;
        ticks(20);
        chk(bus_free, 1'b0, "R9 ticks while idle");

        // Vector table: R2 R3 R4 R5 R7
        for (int k = 0; k < NVEC; k++) begin
            logic [11:0] v;
            int          n;
            v          = VEC[k];
            n          = int'(v[4:0]);
            free_code  = v[11:9];
            idle_class = v[8:7];
            auto_start = v[6];
            start_evt(v[6], v[5]);
            for (int i = 1; i <= n; i++) begin
                tick();
                chk(bus_free, (i == n), "R2/R3 grant timing");
            end
            repeat (3) @(negedge clk);
            chk(bus_free, 1'b1, "R7 grant held");
            ack();
            chk(bus_free, 1'b0, "R7 grant released by ack");
        end

        // R4: end-of-message pulses ignored in request mode
        auto_start = 1'b0; free_code = 3'd1;
        start_evt(1'b1, 1'b0);
        start_evt(1'b1, 1'b1);
        ticks(3);
        chk(bus_free, 1'b0, "R4 eom ignored in request mode");

        // R5: request ignored in automatic mode
        auto_start = 1'b1;
        start_evt(1'b0, 1'b0);
        ticks(3);
        chk(bus_free, 1'b0, "R5 tx_req ignored in auto mode");

        // R9: low line while idle gives no error
        line_hi = 1'b0;
        @(negedge clk);
        line_hi = 1'b1;
        @(negedge clk);
        chk(line_err, 1'b0, "R9 no error when idle");

        // R6: low line during count clears it, one-cycle error
        auto_start = 1'b0; free_code = 3'd3;
        start_evt(1'b0, 1'b0);
        ticks(3);
        line_hi = 1'b0;
        @(negedge clk);
        chk(line_err, 1'b1, "R6 error pulse");
        chk(bus_free, 1'b0, "R6 no grant on low line");
        line_hi = 1'b1;
        @(negedge clk);
        chk(line_err, 1'b0, "R6 error lasts one cycle");
        ticks(4);
        chk(bus_free, 1'b0, "R6 count restarted");
        tick();
        chk(bus_free, 1'b1, "R6 grant after full restart");

        // R7: low line and start event while granted are ignored
        line_hi = 1'b0;
        repeat (2) @(negedge clk);
        chk(bus_free, 1'b1, "R7 grant ignores low line");
        chk(line_err, 1'b0, "R7 no error while granted");
        line_hi = 1'b1;
        start_evt(1'b0, 1'b0);
        ack();
        chk(bus_free, 1'b0, "R7 ack releases");
        free_code = 3'd1;
        ticks(3);
        chk(bus_free, 1'b0, "R7 start event in grant was ignored");

        // R8: restart while counting
        free_code = 3'd4;
        start_evt(1'b0, 1'b0);
        ticks(5);
        start_evt(1'b0, 1'b0);
        ticks(6);
        chk(bus_free, 1'b0, "R8 restart from zero");
        tick();
        chk(bus_free, 1'b1, "R8 grant after restart");
        ack();

        // R1: reset in mid count
        free_code = 3'd2;
        start_evt(1'b0, 1'b0);
        ticks(2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(bus_free, 1'b0, "R1 reset mid count");
        tick();
        chk(bus_free, 1'b0, "R1 count abandoned by reset");

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule